// File: doc/BRIEF.md
# Sixteen-Function ALU Slice

A purely combinational arithmetic/logic slice working on two operand words (four bits wide by default). A four-bit function code together with a mode bit picks one of thirty-two operations. The mode bit splits them into two sets of sixteen. In logic mode the result is a bitwise function of the two operands, and both carry pins are inert. In arithmetic mode the result is the sum of two operand terms plus the carry input. Each term is built bitwise from the operands, or is the constant all-ones that stands for "minus one".

The slice has no clock and no handshake. The result and carry output settle from the inputs within the same cycle. A surrounding datapath registers them as it sees fit. The function codes are part of the behaviour, because a controller decodes against them, so their numeric values are fixed below.

Top module: `fn16_alu_slice`

## Requirements
- R1: With `logic_mode`=1, `result` is, per `fsel`: 1111 A; 1010 B; 0000 NOT A; 0101 NOT B; 1011 A AND B; 1110 A OR B; 0100 NOT(A AND B); 0001 NOT(A OR B); 0110 A XOR B; 1001 NOT(A XOR B); 0010 (NOT A) AND B; 0111 A AND (NOT B); 1000 (NOT A) OR B; 1101 A OR (NOT B); 0011 all zeros; 1100 all ones.
- R2: With `logic_mode`=1, `carry_out` is 0 and `carry_in` has no effect on `result`.
- R3: With `logic_mode`=0 and `carry_in`=0, these codes give plain sums or copies, all modulo 16: 0000 A; 0001 A OR B; 0010 A OR (NOT B); 1001 A plus B; 1100 A plus A.
- R4: With `logic_mode`=0 and `carry_in`=0, these codes add a masked term: 0100 A plus (A AND NOT B); 1000 A plus (A AND B); 0101 (A OR B) plus (A AND NOT B); 1010 (A OR NOT B) plus (A AND B); 1101 (A OR B) plus A; 1110 (A OR NOT B) plus A.
- R5: With `logic_mode`=0 and `carry_in`=0, these codes subtract: 0011 minus 1 (1111); 1111 A minus 1; 0111 (A AND NOT B) minus 1; 1011 (A AND B) minus 1; 0110 A minus B minus 1. "Minus 1" is formed by adding 1111, and A minus B minus 1 is formed by adding NOT B.
- R6: With `logic_mode`=0, `carry_in`=1 adds one to each arithmetic result of R3 to R5, modulo 16.
- R7: With `logic_mode`=0, `carry_out` is bit 4 of the 5-bit sum of the two terms named in R3 to R5 plus `carry_in`. For example, 0011 with `carry_in`=1 gives `result`=0000 and `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = logic set, 0 = arithmetic set |
| carry_in | input | 1 | Carry added in arithmetic mode |
| result | output | 4 | Function result |
| carry_out | output | 1 | Carry out of the arithmetic sum, 0 in logic mode |

## Verification
A hand-worked vector table uses the operand pair 9 and 5. For this pair the XOR, OR-NOT and AND-NOT terms all differ, so a swapped term or an inverted operand changes the answer. The table also includes wrap-around cases (A plus A, minus 1 with carry) that separate a correct fifth-bit carry from a dropped or inverted one. An exhaustive sweep then covers every operand pair, code, mode and carry against an independent model of the listed formulas. A final pass reapplies each logic-mode input with the opposite carry and shows that the result does not move.

// File: rtl/fn16_alu_pkg.sv
package fn16_alu_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] fsel_t;
endpackage

// File: rtl/fn16_logic_unit.sv
module fn16_logic_unit
  import fn16_alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      4'b0000: y = ~a;
      4'b0001: y = ~(a | b);
      4'b0010: y = ~a & b;
      4'b0011: y = '0;
      4'b0100: y = ~(a & b);
      4'b0101: y = ~b;
      4'b0110: y = a ^ b;
      4'b0111: y = a & ~b;
      4'b1000: y = ~a | b;
      4'b1001: y = ~(a ^ b);
      4'b1010: y = b;
      4'b1011: y = a & b;
      4'b1100: y = '1;
      4'b1101: y = a | ~b;
      4'b1110: y = a | b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/fn16_term_sel.sv
module fn16_term_sel
  import fn16_alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        sel,
  output logic [W-1:0] u,
  output logic [W-1:0] v
);
  logic [W-1:0] or_t, orn_t, and_t, andn_t;

  assign or_t   = a | b;
  assign orn_t  = a | ~b;
  assign and_t  = a & b;
  assign andn_t = a & ~b;

  always_comb begin
    unique case (sel)
      4'b0000: begin u = a;      v = '0;     end
      4'b0001: begin u = or_t;   v = '0;     end
      4'b0010: begin u = orn_t;  v = '0;     end
      4'b0011: begin u = '0;     v = '1;     end
      4'b0100: begin u = a;      v = andn_t; end
      4'b0101: begin u = or_t;   v = andn_t; end
      4'b0110: begin u = a;      v = ~b;     end
      4'b0111: begin u = andn_t; v = '1;     end
      4'b1000: begin u = a;      v = and_t;  end
      4'b1001: begin u = a;      v = b;      end
      4'b1010: begin u = orn_t;  v = and_t;  end
      4'b1011: begin u = and_t;  v = '1;     end
      4'b1100: begin u = a;      v = a;      end
      4'b1101: begin u = or_t;   v = a;      end
      4'b1110: begin u = orn_t;  v = a;      end
      default: begin u = a;      v = '1;     end
    endcase
  end
endmodule

// File: rtl/fn16_ripple_add.sv
module fn16_ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign cout = c[W];

  always_comb begin
    if (!$isunknown({x, y, cin})) begin
      // R7: ripple chain agrees with a whole-word sum
      p_sum_exact_r7: assert ({cout, sum} ==
        ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
        else $error("p_sum_exact_r7");
    end
  end
endmodule

// File: rtl/fn16_alu_slice.sv
module fn16_alu_slice
  import fn16_alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   fsel,
  input  logic         logic_mode,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W-1:0] lg_y, term_u, term_v, ar_sum;
  logic         ar_cout;

  fn16_logic_unit #(.W(W)) u_logic (
    .a(opa), .b(opb), .sel(fsel), .y(lg_y)
  );

  fn16_term_sel #(.W(W)) u_terms (
    .a(opa), .b(opb), .sel(fsel), .u(term_u), .v(term_v)
  );

  fn16_ripple_add #(.W(W)) u_add (
    .x(term_u), .y(term_v), .cin(carry_in), .sum(ar_sum), .cout(ar_cout)
  );

  assign result    = logic_mode ? lg_y : ar_sum;
  assign carry_out = logic_mode ? 1'b0 : ar_cout;

  always_comb begin
    if (!$isunknown({opa, opb, fsel, logic_mode, carry_in})) begin
      // R2: no carry leaves the slice in logic mode
      p_no_carry_logic_r2: assert (!(logic_mode && carry_out))
        else $error("p_no_carry_logic_r2");
      // R1: all-ones code in logic mode
      p_ones_r1: assert (!(logic_mode && fsel == 4'b1100) || result == '1)
        else $error("p_ones_r1");
      // R5: subtract form equals A minus B minus 1 plus carry
      p_sub_form_r5: assert (!(!logic_mode && fsel == 4'b0110) ||
        result == W'(opa - opb - W'(1) + W'(carry_in)))
        else $error("p_sub_form_r5");
      // R6: copy code with carry is an increment
      p_incr_r6: assert (!(!logic_mode && fsel == 4'b0000 && carry_in) ||
        result == W'(opa + W'(1)))
        else $error("p_incr_r6");
    end
  end
endmodule

// File: tb/sim_fn16_alu_slice.sv
module sim_fn16_alu_slice;
  logic       clk = 1'b0;
  logic [3:0] opa, opb, fsel, result;
  logic       logic_mode, carry_in, carry_out;
  int         total = 0, bad = 0, cycles = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  fn16_alu_slice u0 (
    .opa(opa), .opb(opb), .fsel(fsel), .logic_mode(logic_mode),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  // {mode, cin, sel[4], a[4], b[4], f[4], c}
  localparam logic [18:0] VEC [14] = '{
    {1'b1, 1'b0, 4'b0110, 4'd9, 4'd5, 4'd12, 1'b0},  // R1 xor
    {1'b1, 1'b0, 4'b1000, 4'd9, 4'd5, 4'd7,  1'b0},  // R1 ~A|B
    {1'b1, 1'b1, 4'b0011, 4'd9, 4'd5, 4'd0,  1'b0},  // R2 zero, cin ignored
    {1'b0, 1'b0, 4'b1001, 4'd9, 4'd5, 4'd14, 1'b0},  // R3 A+B
    {1'b0, 1'b0, 4'b1100, 4'd9, 4'd5, 4'd2,  1'b1},  // R7 A+A wraps
    {1'b0, 1'b0, 4'b0110, 4'd9, 4'd5, 4'd3,  1'b1},  // R5 A-B-1
    {1'b0, 1'b1, 4'b0110, 4'd9, 4'd5, 4'd4,  1'b1},  // R6 A-B
    {1'b0, 1'b0, 4'b0011, 4'd9, 4'd5, 4'd15, 1'b0},  // R5 minus 1
    {1'b0, 1'b1, 4'b0011, 4'd9, 4'd5, 4'd0,  1'b1},  // R6 R7 minus 1 plus 1
    {1'b0, 1'b0, 4'b0100, 4'd9, 4'd5, 4'd1,  1'b1},  // R4 A+(A&~B)
    {1'b0, 1'b0, 4'b1010, 4'd9, 4'd5, 4'd12, 1'b0},  // R4 (A|~B)+(A&B)
    {1'b0, 1'b0, 4'b1111, 4'd9, 4'd5, 4'd8,  1'b1},  // R5 A-1
    {1'b0, 1'b1, 4'b0000, 4'd9, 4'd5, 4'd10, 1'b0},  // R6 A+1
    {1'b1, 1'b0, 4'b1101, 4'd9, 4'd5, 4'd11, 1'b0}   // R1 A|~B
  };

  function automatic logic [4:0] model(input logic m, input logic ci,
                                       input logic [3:0] s, input logic [3:0] a,
                                       input logic [3:0] b);
    logic [4:0] a5, b5, c5, m1;
    a5 = {1'b0, a}; b5 = {1'b0, b}; c5 = {4'b0, ci}; m1 = 5'h0F;
    if (m) begin
      case (s)
        4'h0: return {1'b0, ~a};       4'h1: return {1'b0, ~(a | b)};
        4'h2: return {1'b0, ~a & b};   4'h3: return 5'h00;
        4'h4: return {1'b0, ~(a & b)}; 4'h5: return {1'b0, ~b};
        4'h6: return {1'b0, a ^ b};    4'h7: return {1'b0, a & ~b};
        4'h8: return {1'b0, ~a | b};   4'h9: return {1'b0, ~(a ^ b)};
        4'hA: return {1'b0, b};        4'hB: return {1'b0, a & b};
        4'hC: return 5'h0F;            4'hD: return {1'b0, a | ~b};
        4'hE: return {1'b0, a | b};    default: return {1'b0, a};
      endcase
    end
    case (s)
      4'h0: return a5 + c5;
      4'h1: return {1'b0, a | b} + c5;
      4'h2: return {1'b0, a | ~b} + c5;
      4'h3: return m1 + c5;
      4'h4: return a5 + {1'b0, a & ~b} + c5;
      4'h5: return {1'b0, a | b} + {1'b0, a & ~b} + c5;
      4'h6: return a5 + {1'b0, ~b} + c5;
      4'h7: return {1'b0, a & ~b} + m1 + c5;
      4'h8: return a5 + {1'b0, a & b} + c5;
      4'h9: return a5 + b5 + c5;
      4'hA: return {1'b0, a | ~b} + {1'b0, a & b} + c5;
      4'hB: return {1'b0, a & b} + m1 + c5;
      4'hC: return a5 + a5 + c5;
      4'hD: return {1'b0, a | b} + a5 + c5;
      4'hE: return {1'b0, a | ~b} + a5 + c5;
      default: return a5 + m1 + c5;
    endcase
  endfunction

  task automatic apply(input logic m, input logic ci, input logic [3:0] s,
                       input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    logic_mode = m; carry_in = ci; fsel = s; opa = a; opb = b;
    #1;
  endtask

  task automatic check(input string req, input logic [3:0] ef, input logic ec);
    total++;
    if (result !== ef || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: m=%0b ci=%0b sel=%b a=%0d b=%0d got f=%0d c=%0b exp f=%0d c=%0b",
               req, logic_mode, carry_in, fsel, opa, opb, result, carry_out, ef, ec);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] ref_f;
    // R3: all-zero inputs, copy code gives zero
    apply(1'b0, 1'b0, 4'b0000, 4'd0, 4'd0);
    check("R3 idle", 4'd0, 1'b0);

    for (int i = 0; i < 14; i++) begin
      apply(VEC[i][18], VEC[i][17], VEC[i][16:13], VEC[i][12:9], VEC[i][8:5]);
      check("R1-table R2 R3 R4 R5 R6 R7", VEC[i][4:1], VEC[i][0]);
    end

    // R1 R3 R4 R5 R6 R7: exhaustive sweep against the formula model
    for (int m = 0; m < 2; m++)
      for (int ci = 0; ci < 2; ci++)
        for (int s = 0; s < 16; s++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              logic [4:0] e;
              e = model(1'(m), 1'(ci), 4'(s), 4'(a), 4'(b));
              apply(1'(m), 1'(ci), 4'(s), 4'(a), 4'(b));
              check(m ? "R1 sweep" : "R7 sweep", e[3:0], m ? 1'b0 : e[4]);
            end

    // R2: flipping carry_in in logic mode leaves result unchanged
    for (int s = 0; s < 16; s++) begin
      apply(1'b1, 1'b0, 4'(s), 4'd12, 4'd10);
      ref_f = result;
      apply(1'b1, 1'b1, 4'(s), 4'd12, 4'd10);
      check("R2 carry ignored", ref_f, 1'b0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule